// File: doc/BRIEF.md
# UART Interrupt Status and Line Fan-Out

This block is the interrupt part of a serial port's register file. Single-cycle event pulses come in from the receive, transmit, receive-timeout, modem-status and error logic, and each pulse latches a bit in a raw status register. A mask register picks which raw bits may raise an interrupt. The masked status is the bitwise AND of the two. Software clears pending bits by writing ones to a clear register. Six interrupt lines leave the block: one combined line and one line for each source group.

The same 32-bit bus window of 4 KB also holds the baud divisor registers, an infrared low-power divisor and a FIFO-level setting. A write to the data word marks the transmit interrupt. The last eight words of the window return constant identification bytes. Every access completes in one cycle, and read data is returned one cycle after the request.

Top module: `uart_irq_regs`

## Requirements
- R1: Status bit layout is rx=bit 0, tx=bit 1, rx-timeout=bit 2, modem=bits 6:3, error=bits 10:7. Mask (byte offset 0x020), raw status (0x024) and masked status (0x028) can each be read, and masked always equals raw AND mask.
- R2: A write to the clear offset 0x02C clears each raw bit whose data bit is 1. A read of 0x02C returns 0.
- R3: irqRx, irqTx, irqRxTimeout, irqModem and irqErr are each the OR of their own masked bits. irqAll is the OR of all masked bits.
- R4: An event input pulse sets its raw bits. A write to the data offset 0x000 sets the tx raw bit. A set in the same cycle as a clear of the same bit wins.
- R5: Writes to the raw (0x024) and masked (0x028) offsets change neither raw status nor mask.
- R6: After reset, mask and raw status are 0, all interrupt lines are low, the FIFO-level register (0x01C) reads 0x12, and the integer divisor (0x010), fractional divisor (0x014) and infrared divisor (0x018) read 0.
- R7: Byte offsets 0xFE0 + 4k (k = 0..7) return identification byte k in bits 7:0, with zero above. The default table is F6 18 5A C3 07 91 2E 4D for k = 0..7.
- R8: Reads of unassigned offsets return 0. Writes to them change no register.
- R9: The integer divisor keeps the low 16 bits written, the fractional divisor 6 bits, the FIFO level 6 bits and the infrared divisor 8 bits. The unkept bits read as 0.
- R10: Read data appears on busRdata in the cycle after the request. After a cycle without a read, busRdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address in the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| evRx | input | 1 | Receive event pulse |
| evTx | input | 1 | Transmit event pulse |
| evRxTimeout | input | 1 | Receive-timeout event pulse |
| evModem | input | 4 | Modem-status event pulses |
| evErr | input | 4 | Error event pulses |
| irqAll | output | 1 | Combined interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqTx | output | 1 | Transmit interrupt |
| irqRxTimeout | output | 1 | Receive-timeout interrupt |
| irqModem | output | 1 | Modem-status interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a raw bit that is set and cleared in the same cycle. The stimulus has to raise an event pulse on exactly the edge that a clear write is accepted. The bench does this by driving evRx and the clear write together from a single negative clock edge, then reading raw status back to confirm that the set won. A second difficult case is a pending bit that is masked out. For that, a transmit event is raised while the mask covers only the error bits, and the bench then checks that irqTx stays low while raw status shows the bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int DATA_W    = 32;
  localparam int MODEM_W   = 4;
  localparam int ERR_W     = 4;
  localparam int B_RX      = 0;
  localparam int B_TX      = 1;
  localparam int B_RT      = 2;
  localparam int MODEM_LSB = 3;
  localparam int ERR_LSB   = MODEM_LSB + MODEM_W;
  localparam int RAW_W     = ERR_LSB + ERR_W;
  localparam int LINE_N    = 6;

  localparam int INT_DIV_W  = 16;
  localparam int FRAC_DIV_W = 6;
  localparam int IRDA_W     = 8;
  localparam int FIFO_LVL_W = 6;
  localparam logic [FIFO_LVL_W-1:0] FIFO_LVL_RST = 6'h12;

  localparam int ID_COUNT = 8;
  localparam int ID_IDX_W = $clog2(ID_COUNT);
  localparam logic [8*ID_COUNT-1:0] ID_DEFAULT = 64'h4D2E_9107_C35A_18F6;

  // word indices (byte offset / 4)
  localparam int W_DATA   = 0;
  localparam int W_INTDIV = 4;
  localparam int W_FRAC   = 5;
  localparam int W_IRDA   = 6;
  localparam int W_FIFO   = 7;
  localparam int W_MASK   = 8;
  localparam int W_RAW    = 9;
  localparam int W_MASKED = 10;
  localparam int W_CLEAR  = 11;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_INTDIV, SEL_FRAC, SEL_IRDA, SEL_FIFO,
    SEL_MASK, SEL_RAW, SEL_MASKED, SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic                wrData;
    logic                wrIntDiv;
    logic                wrFrac;
    logic                wrIrda;
    logic                wrFifo;
    logic                wrMask;
    logic                wrClear;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [ID_IDX_W-1:0] idIdx;
  } ctrlStrobe_t;

  // Status bits feeding each output line: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error
  function automatic logic [RAW_W-1:0] lineMask(input int k);
    logic [RAW_W-1:0] m;
    m = '0;
    case (k)
      0:       m = '1;
      1:       m[B_RX] = 1'b1;
      2:       m[B_TX] = 1'b1;
      3:       m[B_RT] = 1'b1;
      4:       m[MODEM_LSB +: MODEM_W] = '1;
      default: m[ERR_LSB +: ERR_W] = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] ID_BASE = WORD_W'((2 ** WORD_W) - ID_COUNT);

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedByteLane;
  logic              isRd;
  logic              isWr;
  logic              idHit;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedByteLane = busAddr[1:0];
  assign isRd           = busValid && !busWrite;
  assign isWr           = busValid && busWrite;
  assign idHit          = wordIdx >= ID_BASE;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_ZERO;
    strobe.rdEn  = isRd;
    strobe.idIdx = wordIdx[ID_IDX_W-1:0];
    if (idHit) begin
      if (isRd) strobe.rdSel = SEL_ID;
    end else begin
      case (wordIdx)
        WORD_W'(W_DATA):   strobe.wrData   = isWr;
        WORD_W'(W_INTDIV): begin strobe.wrIntDiv = isWr; if (isRd) strobe.rdSel = SEL_INTDIV; end
        WORD_W'(W_FRAC):   begin strobe.wrFrac   = isWr; if (isRd) strobe.rdSel = SEL_FRAC;   end
        WORD_W'(W_IRDA):   begin strobe.wrIrda   = isWr; if (isRd) strobe.rdSel = SEL_IRDA;   end
        WORD_W'(W_FIFO):   begin strobe.wrFifo   = isWr; if (isRd) strobe.rdSel = SEL_FIFO;   end
        WORD_W'(W_MASK):   begin strobe.wrMask   = isWr; if (isRd) strobe.rdSel = SEL_MASK;   end
        WORD_W'(W_RAW):    if (isRd) strobe.rdSel = SEL_RAW;
        WORD_W'(W_MASKED): if (isRd) strobe.rdSel = SEL_MASKED;
        WORD_W'(W_CLEAR):  strobe.wrClear = isWr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter logic [8*ID_COUNT-1:0] ID_TABLE = ID_DEFAULT
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               evRx,
  input  logic               evTx,
  input  logic               evRxTimeout,
  input  logic [MODEM_W-1:0] evModem,
  input  logic [ERR_W-1:0]   evErr,
  output logic [DATA_W-1:0]  busRdata,
  output logic [RAW_W-1:0]   rawQ,
  output logic [RAW_W-1:0]   maskQ,
  output logic [LINE_N-1:0]  irqVec
);
  logic [INT_DIV_W-1:0]  intDivQ;
  logic [FRAC_DIV_W-1:0] fracDivQ;
  logic [IRDA_W-1:0]     irdaQ;
  logic [FIFO_LVL_W-1:0] fifoLvlQ;
  logic [RAW_W-1:0]      setVec;
  logic [RAW_W-1:0]      clrVec;
  logic [RAW_W-1:0]      maskedVec;
  logic [DATA_W-1:0]     rdMux;
  logic [DATA_W-1:0]     unusedWdata;

  assign unusedWdata = busWdata;
  assign setVec    = {evErr, evModem, evRxTimeout, evTx | strobe.wrData, evRx};
  assign clrVec    = strobe.wrClear ? busWdata[RAW_W-1:0] : '0;
  assign maskedVec = rawQ & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ     <= '0;
      maskQ    <= '0;
      intDivQ  <= '0;
      fracDivQ <= '0;
      irdaQ    <= '0;
      fifoLvlQ <= FIFO_LVL_RST;
    end else begin
      rawQ <= (rawQ & ~clrVec) | setVec;
      if (strobe.wrMask)   maskQ    <= busWdata[RAW_W-1:0];
      if (strobe.wrIntDiv) intDivQ  <= busWdata[INT_DIV_W-1:0];
      if (strobe.wrFrac)   fracDivQ <= busWdata[FRAC_DIV_W-1:0];
      if (strobe.wrIrda)   irdaQ    <= busWdata[IRDA_W-1:0];
      if (strobe.wrFifo)   fifoLvlQ <= busWdata[FIFO_LVL_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    case (strobe.rdSel)
      SEL_INTDIV: rdMux = DATA_W'(intDivQ);
      SEL_FRAC:   rdMux = DATA_W'(fracDivQ);
      SEL_IRDA:   rdMux = DATA_W'(irdaQ);
      SEL_FIFO:   rdMux = DATA_W'(fifoLvlQ);
      SEL_MASK:   rdMux = DATA_W'(maskQ);
      SEL_RAW:    rdMux = DATA_W'(rawQ);
      SEL_MASKED: rdMux = DATA_W'(maskedVec);
      SEL_ID:     rdMux = DATA_W'(ID_TABLE[8*strobe.idIdx +: 8]);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
    else                  busRdata <= '0;
  end

  for (genvar k = 0; k < LINE_N; k++) begin : g_line
    localparam logic [RAW_W-1:0] SEL = lineMask(k);
    assign irqVec[k] = |(maskedVec & SEL);
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [8*ID_COUNT-1:0] ID_TABLE = ID_DEFAULT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               evRx,
  input  logic               evTx,
  input  logic               evRxTimeout,
  input  logic [MODEM_W-1:0] evModem,
  input  logic [ERR_W-1:0]   evErr,
  output logic               irqAll,
  output logic               irqRx,
  output logic               irqTx,
  output logic               irqRxTimeout,
  output logic               irqModem,
  output logic               irqErr
);
  ctrlStrobe_t       strobe;
  logic [RAW_W-1:0]  rawQ;
  logic [RAW_W-1:0]  maskQ;
  logic [LINE_N-1:0] irqVec;

  uart_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe)
  );

  uart_irq_dp #(.ID_TABLE(ID_TABLE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .evRx(evRx), .evTx(evTx), .evRxTimeout(evRxTimeout), .evModem(evModem), .evErr(evErr),
    .busRdata(busRdata), .rawQ(rawQ), .maskQ(maskQ), .irqVec(irqVec)
  );

  assign irqAll       = irqVec[0];
  assign irqRx        = irqVec[1];
  assign irqTx        = irqVec[2];
  assign irqRxTimeout = irqVec[3];
  assign irqModem     = irqVec[4];
  assign irqErr       = irqVec[5];
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               evRx,
  input logic               evTx,
  input logic               evRxTimeout,
  input logic [MODEM_W-1:0] evModem,
  input logic [ERR_W-1:0]   evErr,
  input logic               irqAll,
  input logic               irqRx,
  input logic               irqTx,
  input logic               irqRxTimeout,
  input logic               irqModem,
  input logic               irqErr,
  input logic [RAW_W-1:0]   rawQ,
  input logic [RAW_W-1:0]   maskQ
);
  localparam int WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] wordIdx;
  logic anyEv;
  logic isRd;
  logic isWr;
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign anyEv   = evRx | evTx | evRxTimeout | (|evModem) | (|evErr);
  assign isRd    = busValid && !busWrite;
  assign isWr    = busValid && busWrite;

  p_rx_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqRx == (rawQ[B_RX] & maskQ[B_RX]));
  p_modem_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqModem == |(rawQ[MODEM_LSB +: MODEM_W] & maskQ[MODEM_LSB +: MODEM_W]));
  p_combined_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqAll == (irqRx | irqTx | irqRxTimeout | irqModem | irqErr));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && wordIdx == WORD_W'(W_CLEAR) && !anyEv) |=>
      ((rawQ & $past(busWdata[RAW_W-1:0])) == '0));
  p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && wordIdx == WORD_W'(W_CLEAR)) |=> busRdata == '0);
  p_tx_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && wordIdx == WORD_W'(W_DATA)) |=> rawQ[B_TX]);
  p_status_ro_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && (wordIdx == WORD_W'(W_RAW) || wordIdx == WORD_W'(W_MASKED)) && !anyEv) |=>
      ($stable(rawQ) && $stable(maskQ)));
  p_id_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && wordIdx >= WORD_W'((2 ** WORD_W) - ID_COUNT)) |=> busRdata[DATA_W-1:8] == '0);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> busRdata == '0);
endmodule

bind uart_irq_regs uart_irq_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .evRx(evRx), .evTx(evTx),
  .evRxTimeout(evRxTimeout), .evModem(evModem), .evErr(evErr), .irqAll(irqAll),
  .irqRx(irqRx), .irqTx(irqTx), .irqRxTimeout(irqRxTimeout), .irqModem(irqModem),
  .irqErr(irqErr), .rawQ(rawQ), .maskQ(maskQ)
);

// File: tb/uart_irq_regs_tb_top.sv
`timescale 1ns/1ps
module uart_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evRx = 1'b0, evTx = 1'b0, evRxTimeout = 1'b0;
  logic [3:0]  evModem = '0, evErr = '0;
  logic        irqAll, irqRx, irqTx, irqRxTimeout, irqModem, irqErr;

  int   nChecks = 0;
  int   nFails  = 0;
  logic sawRead = 1'b0;
  bit   done    = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  uart_irq_regs dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evRx(evRx), .evTx(evTx),
    .evRxTimeout(evRxTimeout), .evModem(evModem), .evErr(evErr), .irqAll(irqAll),
    .irqRx(irqRx), .irqTx(irqTx), .irqRxTimeout(irqRxTimeout), .irqModem(irqModem),
    .irqErr(irqErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: reads accepted at a rising edge are compared at the next falling edge
  always @(posedge clk) sawRead <= busValid && !busWrite;
  always @(negedge clk) begin
    if (sawRead) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected read data", busRdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(busRdata === e, t, busRdata, e);
      end
    end
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic pulse(input logic r, input logic t, input logic rt, input logic [3:0] m, input logic [3:0] e);
    evRx = r; evTx = t; evRxTimeout = rt; evModem = m; evErr = e;
    @(negedge clk);
    evRx = 1'b0; evTx = 1'b0; evRxTimeout = 1'b0; evModem = '0; evErr = '0;
  endtask

  task automatic lines(input logic [5:0] e, input string t);
    logic [5:0] a;
    a = {irqErr, irqModem, irqRxTimeout, irqTx, irqRx, irqAll};
    chk(a === e, t, 32'(a), 32'(e));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    lines(6'b000000, "R6 lines after reset");
    busRd(12'h020, 32'h0,  "R6 mask reset");
    busRd(12'h024, 32'h0,  "R6 raw reset");
    busRd(12'h01C, 32'h12, "R6 fifo level reset");
    busRd(12'h010, 32'h0,  "R6 int divisor reset");
    busRd(12'h014, 32'h0,  "R6 frac divisor reset");
    busRd(12'h018, 32'h0,  "R6 irda reset");

    busWr(12'h010, 32'hABCD_1234);
    busWr(12'h014, 32'hFFFF_FFFF);
    busWr(12'h018, 32'h0000_01FF);
    busWr(12'h01C, 32'hFFFF_FFFF);
    busRd(12'h010, 32'h1234, "R9 int divisor 16 bits");
    busRd(12'h014, 32'h3F,   "R9 frac divisor 6 bits");
    busRd(12'h018, 32'hFF,   "R9 irda 8 bits");
    busRd(12'h01C, 32'h3F,   "R9 fifo level 6 bits");

    pulse(1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
    busRd(12'h024, 32'h001, "R4 rx event sets raw");
    busRd(12'h028, 32'h000, "R1 masked with zero mask");
    lines(6'b000000, "R3 lines with zero mask");

    busWr(12'h020, 32'h0000_07FF);
    busRd(12'h028, 32'h001, "R1 masked after unmask");
    lines(6'b000011, "R3 rx line and combined");

    busWr(12'h000, 32'h0000_0041);
    busRd(12'h024, 32'h003, "R4 data write sets tx");
    lines(6'b000111, "R3 tx line");

    pulse(1'b0, 1'b0, 1'b1, 4'b0010, 4'b1000);
    busRd(12'h024, 32'h417, "R4 timeout, modem, error events");
    lines(6'b111111, "R3 all lines");

    busWr(12'h024, 32'h0);
    busWr(12'h028, 32'h0);
    busRd(12'h024, 32'h417, "R5 raw unchanged by status writes");
    busRd(12'h020, 32'h7FF, "R5 mask unchanged by status writes");

    busRd(12'h02C, 32'h0, "R2 clear reads zero");
    busWr(12'h02C, 32'h0000_0013);
    busRd(12'h024, 32'h404, "R2 write-one-to-clear");
    lines(6'b101001, "R3 lines after clear");

    busWr(12'h020, 32'h0000_0400);
    busRd(12'h028, 32'h400, "R1 masked with error-only mask");
    lines(6'b100001, "R3 masked timeout line");

    pulse(1'b0, 1'b1, 1'b0, 4'h0, 4'h0);
    busRd(12'h024, 32'h406, "R4 tx event input");
    lines(6'b100001, "R3 tx masked out");

    // same-cycle set and clear of the rx bit
    evRx = 1'b1;
    busWr(12'h02C, 32'h0000_0001);
    evRx = 1'b0;
    busRd(12'h024, 32'h407, "R4 set wins over clear");

    busWr(12'h02C, 32'h0000_07FF);
    busRd(12'h024, 32'h0, "R2 clear all");
    lines(6'b000000, "R3 lines after clear all");

    busRd(12'hFE0, 32'hF6, "R7 id byte 0");
    busRd(12'hFE4, 32'h18, "R7 id byte 1");
    busRd(12'hFE8, 32'h5A, "R7 id byte 2");
    busRd(12'hFEC, 32'hC3, "R7 id byte 3");
    busRd(12'hFF0, 32'h07, "R7 id byte 4");
    busRd(12'hFF4, 32'h91, "R7 id byte 5");
    busRd(12'hFF8, 32'h2E, "R7 id byte 6");
    busRd(12'hFFC, 32'h4D, "R7 id byte 7");

    busWr(12'h030, 32'hFFFF_FFFF);
    busWr(12'h804, 32'hFFFF_FFFF);
    busWr(12'hFE0, 32'hFFFF_FFFF);
    busRd(12'h030, 32'h0,    "R8 unassigned read 0x030");
    busRd(12'h804, 32'h0,    "R8 unassigned read 0x804");
    busRd(12'hFE0, 32'hF6,   "R8 id byte unchanged by write");
    busRd(12'h020, 32'h400,  "R8 mask unchanged");
    busRd(12'h024, 32'h0,    "R8 raw unchanged");
    busRd(12'h010, 32'h1234, "R8 int divisor unchanged");
    busRd(12'h01C, 32'h3F,   "R8 fifo level unchanged");
    lines(6'b000000, "R8 lines unchanged");

    @(negedge clk);
    chk(busRdata === 32'h0, "R10 read data zero after idle", busRdata, 32'h0);
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) chk(1'b0, "R10 reads left unanswered", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule